// File: doc/BRIEF.md
# SHA-256 Message Schedule Streamer

This block turns one 512-bit message block into the 64 schedule words that the SHA-256 compression rounds consume, and hands them out one per cycle. The sixteen 32-bit message words are loaded one at a time over a valid/ready input. The block then streams W[0] to W[63] over a valid/ready output, so that a round engine can take each word as it needs it, with no separate 64-cycle expansion pass in front of the rounds.

The words are kept in a 16-entry buffer that has a single read port. Each cycle reads one entry, at the slot of W[t-15]. That value feeds the σ0 term and is also kept in a register, where it serves as W[t-16] on the next step. A seven-deep delay line of the words already sent supplies W[t-2] and W[t-7]. Each new word W[t] is written back into the slot that held W[t-16].

Top module: `sha2_sched_gen`

## Requirements
- R1: After reset, in_ready_o is 1 and out_valid_o is 0.
- R2: The block accepts exactly 16 input words. After the 16th input handshake, in_ready_o is 0 and out_valid_o is 1 with out_idx_o equal to 0 in the next cycle.
- R3: The first word loaded is W[0], the most significant 32 bits of the block. Outputs W[0]..W[15] are the loaded words, unchanged and in load order.
- R4: For 16 ≤ t ≤ 63, the output word is σ1(W[t-2]) + W[t-7] + σ0(W[t-15]) + W[t-16] modulo 2^32. Here σ0(x) = ROTR7(x) ^ ROTR18(x) ^ SHR3(x) and σ1(x) = ROTR17(x) ^ ROTR19(x) ^ SHR10(x).
- R5: Exactly 64 words are emitted, and out_idx_o steps 0, 1, …, 63 by one per output handshake. After the handshake at index 63, out_valid_o is 0 and in_ready_o is 1.
- R6: While out_valid_o is 1 and out_ready_i is 0, out_valid_o, out_word_o and out_idx_o hold their values into the next cycle.
- R7: in_ready_o and out_valid_o are never both 1. Input words offered while the block is streaming are ignored and do not alter the emitted schedule.
- R8: A block loaded directly after the previous schedule ends yields its own correct schedule, with no leftover from the earlier block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input message word valid |
| in_ready_o | output | 1 | Block ready to accept a message word |
| in_word_i | input | 32 | Message word, loaded in order W[0]..W[15] |
| out_valid_o | output | 1 | Schedule word valid |
| out_ready_i | input | 1 | Consumer ready to take the schedule word |
| out_word_o | output | 32 | Schedule word W[out_idx_o] |
| out_idx_o | output | 6 | Index t of the word on out_word_o |

## Verification
The assertions check the handshake rules on every cycle. Load and stream are mutually exclusive, a stalled word stays stable, the index advances by one per output handshake, the stream opens at index 0 and the block returns to loading after index 63. The values of the words can only be shown by the bench's scenarios: the scoreboard checks each streamed word against a model of the recurrence. It does this for the padded "abc" block and for random blocks, under several ready patterns, with junk offered on the input during streaming, and with blocks loaded back to back.

// File: rtl/sha2_sched_pkg.sv
package sha2_sched_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t rotr(input word_t x, input int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t ssig0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t ssig1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction
endpackage

// File: rtl/sched_word_ram.sv
module sched_word_ram #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // single read port
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sched_tap_line.sv
module sched_tap_line #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 7
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    shift_i,
  input  logic [W-1:0]            din_i,
  output logic [DEPTH-1:0][W-1:0] taps_o
);
  logic [DEPTH-1:0][W-1:0] stage_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [W-1:0] src;
    if (g == 0) begin : g_head
      assign src = din_i;
    end else begin : g_body
      assign src = stage_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stage_q[g] <= '0;
      else if (shift_i) stage_q[g] <= src;
    end
  end

  // taps_o[k] = word sent k+1 handshakes ago
  assign taps_o = stage_q;
endmodule

// File: rtl/sha2_sched_gen.sv
module sha2_sched_gen #(
  parameter int unsigned NUM_OUT = 64,
  parameter int unsigned WIN     = 16,
  parameter int unsigned LAG_A   = 2,
  parameter int unsigned LAG_B   = 7,
  localparam int unsigned W      = sha2_sched_pkg::WORD_W,
  localparam int unsigned IDX_W  = $clog2(NUM_OUT),
  localparam int unsigned AW     = $clog2(WIN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [W-1:0]     in_word_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [W-1:0]     out_word_o,
  output logic [IDX_W-1:0] out_idx_o
);
  import sha2_sched_pkg::*;

  localparam logic [IDX_W-1:0] WIN_C  = IDX_W'(WIN);
  localparam logic [IDX_W-1:0] LAST_C = IDX_W'(NUM_OUT - 1);
  localparam logic [IDX_W-1:0] LOADL_C = IDX_W'(WIN - 1);

  logic             loading_q;
  logic [IDX_W-1:0] cnt_q;
  word_t            old_q;   // W[t-16] for t>=16, W[t] for t<16
  logic             in_fire, out_fire, ram_we;
  logic [AW-1:0]    raddr;
  word_t            rdata, w_new, w_cur, ram_wdata;
  logic [LAG_B-1:0][W-1:0] taps;

  assign in_ready_o  = loading_q;
  assign out_valid_o = !loading_q;
  assign in_fire     = in_valid_i && loading_q;
  assign out_fire    = out_ready_i && !loading_q;

  // rdata = W[t-15], slot of W[t+1] for t<15
  assign raddr     = cnt_q[AW-1:0] + AW'(1);
  assign w_new     = ssig1(taps[LAG_A-1]) + taps[LAG_B-1] + ssig0(rdata) + old_q;
  assign w_cur     = (cnt_q < WIN_C) ? old_q : w_new;
  assign ram_we    = in_fire || (out_fire && cnt_q >= WIN_C);
  assign ram_wdata = loading_q ? in_word_i : w_new;

  sched_word_ram #(.DEPTH(WIN), .W(W)) u_ram (
    .clk_i  (clk_i),
    .we_i   (ram_we),
    .waddr_i(cnt_q[AW-1:0]),
    .wdata_i(ram_wdata),
    .raddr_i(raddr),
    .rdata_o(rdata)
  );

  sched_tap_line #(.W(W), .DEPTH(LAG_B)) u_taps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(out_fire),
    .din_i  (w_cur),
    .taps_o (taps)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loading_q <= 1'b1;
      cnt_q     <= '0;
      old_q     <= '0;
    end else if (in_fire) begin
      if (cnt_q == '0) old_q <= in_word_i;
      if (cnt_q == LOADL_C) begin
        loading_q <= 1'b0;
        cnt_q     <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (out_fire) begin
      old_q <= rdata;
      if (cnt_q == LAST_C) begin
        loading_q <= 1'b1;
        cnt_q     <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign out_word_o = w_cur;
  assign out_idx_o  = cnt_q;
endmodule

// File: rtl/sha2_sched_gen_chk.sv
module sha2_sched_gen_chk #(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned LAST  = 63
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [31:0]      out_word_o,
  input logic [IDX_W-1:0] out_idx_o
);
  assert_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));

  assert_stall_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_word_o) && $stable(out_idx_o)));

  assert_idx_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_idx_o != IDX_W'(LAST))
      |=> (out_valid_o && out_idx_o == $past(out_idx_o) + 1'b1));

  assert_end_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_idx_o == IDX_W'(LAST)) |=> (!out_valid_o && in_ready_o));

  assert_start_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> out_idx_o == '0);
endmodule

bind sha2_sched_gen sha2_sched_gen_chk #(.IDX_W(IDX_W), .LAST(NUM_OUT - 1)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_word_o (out_word_o),
  .out_idx_o  (out_idx_o)
);

// File: tb/sim_sha2_sched_gen.sv
`timescale 1ns/1ps
module sim_sha2_sched_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_word;
  logic [5:0]  out_idx;

  always #2.5 clk = ~clk;

  sha2_sched_gen u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_word_i(in_word),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_word_o(out_word), .out_idx_o(out_idx)
  );

  int checks = 0;
  int fails = 0;
  int rdy_mode = 0;
  int exp_idx = 0;
  bit summary_done = 0;
  logic [31:0] exp_q[$];
  bit prev_stall = 0;
  logic [31:0] prev_w;
  logic [5:0]  prev_i;

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(in_ready && out_valid), "R7", {30'd0, in_ready, out_valid}, 32'd0);
      if (prev_stall) begin
        chk(out_valid == 1'b1, "R6", {31'd0, out_valid}, 32'd1);
        chk(out_word == prev_w, "R6", out_word, prev_w);
        chk(out_idx == prev_i, "R6", {26'd0, out_idx}, {26'd0, prev_i});
      end
      case (rdy_mode)
        0:       out_ready = 1'b1;
        1:       out_ready = ($urandom % 2) == 0;
        default: out_ready = ($urandom % 4) == 0;
      endcase
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R5", {26'd0, out_idx}, 32'hffffffff);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(out_word == e, (exp_idx < 16) ? "R3" : "R4", out_word, e);
          chk(out_idx == 6'(exp_idx), "R5", {26'd0, out_idx}, 32'(exp_idx));
          exp_idx = (exp_idx == 63) ? 0 : exp_idx + 1;
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_w = out_word;
      prev_i = out_idx;
    end
  end

  task automatic load_block(input logic [31:0] blk[16], input bit junk, input bit gaps);
    logic [31:0] w[64];
    for (int t = 0; t < 64; t++) begin
      if (t < 16) w[t] = blk[t];
      else w[t] = (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7]
                + (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];
      exp_q.push_back(w[t]);
    end
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (gaps && (i % 3 == 1)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_word = blk[i];
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    // R2: loading closed, stream open at index 0
    chk(in_ready == 1'b0, "R2", {31'd0, in_ready}, 32'd0);
    chk(out_valid == 1'b1, "R2", {31'd0, out_valid}, 32'd1);
    chk(out_idx == 6'd0, "R2", {26'd0, out_idx}, 32'd0);
    // R7: junk offered during streaming must be ignored
    in_valid = junk;
    in_word = $urandom;
    while (exp_q.size() != 0) begin
      @(negedge clk);
      if (junk) in_word = $urandom;
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R5", {31'd0, out_valid}, 32'd0);
    chk(in_ready == 1'b1, "R5", {31'd0, in_ready}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] blk[16];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", {31'd0, in_ready}, 32'd1);
    chk(out_valid == 1'b0, "R1", {31'd0, out_valid}, 32'd0);

    // padded "abc" block, R3 R4
    for (int i = 0; i < 16; i++) blk[i] = '0;
    blk[0] = 32'h61626380;
    blk[15] = 32'h00000018;
    rdy_mode = 0;
    load_block(blk, 0, 0);

    // random blocks, back to back (R8), varied ready patterns (R6), junk (R7)
    for (int b = 0; b < 6; b++) begin
      for (int i = 0; i < 16; i++) blk[i] = $urandom;
      rdy_mode = b % 3;
      load_block(blk, b[0], b[1]);
    end

    // R8: all-ones block after random traffic
    for (int i = 0; i < 16; i++) blk[i] = 32'hffffffff;
    rdy_mode = 2;
    load_block(blk, 1, 0);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule